// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Slave

This block is the device side of a 2048-bit serial EEPROM reached over a three-wire serial bus. The wires are a select line, a serial clock and a serial data input, plus a data output that has its own output enable so it can be tri-stated. All four bus inputs are oversampled by the system clock through synchronizers. The block acts on rising edges of the serial clock seen while the select line is high. Storage is an internal register array. A strap input chooses either 128 words of 16 bits or 256 words of 8 bits.

Every instruction starts with a 1 bit, followed by a two-bit opcode and then the address. The instructions are: read, write, erase, lock, unlock, fill-all-with-ones and fill-all-with-data. Any change to the contents starts a self-timed write cycle that lasts a parameterized number of system clocks. During that cycle the block refuses new instructions. When it is selected, it reports ready or busy on the data output. A single 1 clocked in returns the output to high impedance, so the data input and data output can share one wire.

Top module: `ser_eeprom`

## Requirements
- R1: With `wide16_i` high the array holds 128 words of 16 bits. With it low it holds 256 bytes: byte address a maps to bits [15:8] of word a>>1 when a[0] is 1, and to bits [7:0] when a[0] is 0. After reset every word reads 16'hFFFF.
- R2: An instruction is sampled on rising serial-clock edges while selected. It is a start bit of 1, then a 2-bit opcode, then the address MSB first: 7 bits when `wide16_i` is high and 8 bits when it is low, so 10 or 11 bits in total. Opcodes: 10 read, 01 write, 11 erase, 00 extended.
- R3: A read drives a 0 dummy bit after the last address bit. It then drives the addressed word MSB first, one bit per rising edge (16 or 8 bits). While still selected it continues with the next address, wrapping from the top address to 0.
- R4: A write shifts in one word of data MSB first. When select falls after the last data bit, the word is stored and the write cycle starts.
- R5: Erase stores all ones at the addressed word. For extended opcode 00, the two top address bits choose the operation: 10 writes all ones to every word, 01 takes one word of data and stores it into every word (a byte is replicated into both halves in 8-bit mode), 11 is unlock and 00 is lock.
- R6: `sdo_oe_o` is low whenever select is low. While selected it is high only during a read or during status reporting.
- R7: After a write cycle starts and select is high, the output drives 0 while the cycle runs, which lasts `WR_CYCLES` system clocks. It drives 1 once the cycle has finished.
- R8: While a write cycle runs, no start bit is accepted. Bits clocked in start nothing and the output does not drive read data.
- R9: Write, erase and both fill operations do nothing, and start no write cycle, unless an unlock has been issued since reset or since the last lock.
- R10: Select going low aborts any partly received instruction, and nothing is stored. It does not stop a write cycle that has already started.
- R11: While status is being reported, a 1 clocked in returns the output to high impedance and is not taken as a start bit. An instruction may follow it in the same selection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wide16_i | input | 1 | Organization strap: 1 selects 16-bit words, 0 selects bytes |
| sel_i | input | 1 | Bus select, active high |
| sclk_i | input | 1 | Serial bus clock |
| sdi_i | input | 1 | Serial data in |
| sdo_o | output | 1 | Serial data out |
| sdo_oe_o | output | 1 | Output enable for sdo_o; low means high impedance |

## Verification
Status reporting and instruction decode compete for the same serial-clock edge. A 1 clocked in while ready/busy is shown could be taken either as the dummy bit that releases the output or as a start bit. The bench completes a write and waits for the ready level. It then clocks a single 1 followed directly by a full read instruction in the same selection. It judges the result by the dummy 0 and the word arriving exactly where a read that starts after the releasing bit would place them. A second case has the releasing 1 arrive while the cycle is still busy and then sends a full read. That read must produce no output, and the interrupted selection must not cut short the running write.

// File: rtl/ser_eeprom_pkg.sv
package ser_eeprom_pkg;
  typedef enum logic [2:0] {ST_IDLE, ST_OPC, ST_ADR, ST_DAT, ST_RD, ST_WAIT} st_e;
  typedef enum logic [1:0] {CM_NONE, CM_WORD, CM_ALL} cm_e;

  localparam logic [1:0] OP_EXT = 2'b00;
  localparam logic [1:0] OP_WR  = 2'b01;
  localparam logic [1:0] OP_RD  = 2'b10;
  localparam logic [1:0] OP_ER  = 2'b11;

  localparam logic [1:0] EX_LOCK      = 2'b00;
  localparam logic [1:0] EX_FILL_DATA = 2'b01;
  localparam logic [1:0] EX_FILL_ONES = 2'b10;
  localparam logic [1:0] EX_UNLOCK    = 2'b11;
endpackage

// File: rtl/ser_eeprom_sync.sv
module ser_eeprom_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] r_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) r_q <= '0;
        else         r_q <= d_i;
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) r_q <= '0;
        else         r_q <= {r_q[STAGES-2:0], d_i};
    end
  endgenerate

  assign q_o = r_q[STAGES-1];
endmodule

// File: rtl/ser_eeprom_timer.sv
module ser_eeprom_timer #(
  parameter int CYCLES = 5000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o
);
  localparam int CW = $clog2(CYCLES + 1);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)           cnt_q <= '0;
    else if (start_i)      cnt_q <= CW'(CYCLES);
    else if (cnt_q != '0)  cnt_q <= cnt_q - CW'(1);

  assign busy_o = (cnt_q != '0);
endmodule

// File: rtl/ser_eeprom_array.sv
module ser_eeprom_array #(
  parameter int WORDS = 128,
  parameter int WW    = 16
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     we_i,
  input  logic                     all_i,
  input  logic [$clog2(WORDS)-1:0] waddr_i,
  input  logic [WW-1:0]            wdata_i,
  input  logic [WW-1:0]            wmask_i,
  input  logic [$clog2(WORDS)-1:0] raddr_i,
  output logic [WW-1:0]            rdata_o
);
  localparam int AW = $clog2(WORDS);
  logic [WW-1:0] mem_q [WORDS];

  for (genvar i = 0; i < WORDS; i++) begin : g_word
    always_ff @(posedge clk_i or negedge rst_ni)
      if (!rst_ni)
        mem_q[i] <= '1;
      else if (we_i && (all_i || waddr_i == AW'(i)))
        mem_q[i] <= (mem_q[i] & ~wmask_i) | (wdata_i & wmask_i);
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/ser_eeprom.sv
module ser_eeprom
  import ser_eeprom_pkg::*;
#(
  parameter int MEM_BITS    = 2048,
  parameter int WORD_W      = 16,
  parameter int WR_CYCLES   = 5000,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wide16_i,
  input  logic sel_i,
  input  logic sclk_i,
  input  logic sdi_i,
  output logic sdo_o,
  output logic sdo_oe_o
);
  localparam int WORDS  = MEM_BITS / WORD_W;
  localparam int AW_W   = $clog2(WORDS);
  localparam int AW_B   = AW_W + 1;
  localparam int BYTE_W = WORD_W / 2;
  localparam int CNT_W  = $clog2(WORD_W) + 1;

  // bus synchronizers, equal depth keeps the three lines aligned
  logic sel_s, sclk_s, sdi_s;
  ser_eeprom_sync #(.STAGES(SYNC_STAGES)) u_sync_sel (.clk_i, .rst_ni, .d_i(sel_i),  .q_o(sel_s));
  ser_eeprom_sync #(.STAGES(SYNC_STAGES)) u_sync_clk (.clk_i, .rst_ni, .d_i(sclk_i), .q_o(sclk_s));
  ser_eeprom_sync #(.STAGES(SYNC_STAGES)) u_sync_dat (.clk_i, .rst_ni, .d_i(sdi_i),  .q_o(sdi_s));

  logic sclk_d_q, sel_d_q;
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      sclk_d_q <= 1'b0;
      sel_d_q  <= 1'b0;
    end else begin
      sclk_d_q <= sclk_s;
      sel_d_q  <= sel_s;
    end

  logic sclk_rise, sel_fall;
  assign sclk_rise = sclk_s & ~sclk_d_q & sel_s;
  assign sel_fall  = ~sel_s & sel_d_q;

  st_e              st_q;
  cm_e              cm_q;
  logic [1:0]       op_q;
  logic [AW_B-1:0]  adr_q;
  logic [WORD_W-1:0] dat_q, sh_q;
  logic [CNT_W-1:0] cnt_q;
  logic             unlk_q, stat_q, ones_q, rd_bit_q;
  logic             sdo_q, oe_q;
  logic             busy;

  logic [CNT_W-1:0] adr_last, dat_last;
  logic [AW_B-1:0]  adr_full, adr_inc, rd_adr;
  logic [1:0]       ext_sel;
  logic [WORD_W-1:0] rword, rd_val, wdata, wmask;
  logic [AW_W-1:0]  raddr, waddr;
  logic             commit;

  assign adr_last = wide16_i ? CNT_W'(AW_W - 1) : CNT_W'(AW_B - 1);
  assign dat_last = wide16_i ? CNT_W'(WORD_W - 1) : CNT_W'(BYTE_W - 1);
  assign adr_full = {adr_q[AW_B-2:0], sdi_s};
  assign ext_sel  = wide16_i ? adr_full[AW_W-1 -: 2] : adr_full[AW_B-1 -: 2];
  assign adr_inc  = wide16_i ? {1'b0, adr_q[AW_W-1:0] + AW_W'(1)} : adr_q + AW_B'(1);
  assign rd_adr   = (st_q == ST_ADR) ? adr_full : adr_inc;

  assign raddr  = wide16_i ? rd_adr[AW_W-1:0] : rd_adr[AW_B-1:1];
  assign rd_val = wide16_i ? rword
                : {{BYTE_W{1'b0}}, (rd_adr[0] ? rword[WORD_W-1:BYTE_W] : rword[BYTE_W-1:0])};

  // storage commit happens on select release with an armed operation
  assign commit = sel_fall && (cm_q != CM_NONE);
  assign waddr  = wide16_i ? adr_q[AW_W-1:0] : adr_q[AW_B-1:1];
  assign wdata  = ones_q ? '1 : (wide16_i ? dat_q : {2{dat_q[BYTE_W-1:0]}});
  assign wmask  = (wide16_i || cm_q == CM_ALL) ? '1
                : (adr_q[0] ? {{BYTE_W{1'b1}}, {BYTE_W{1'b0}}}
                            : {{BYTE_W{1'b0}}, {BYTE_W{1'b1}}});

  ser_eeprom_array #(.WORDS(WORDS), .WW(WORD_W)) u_array (
    .clk_i, .rst_ni,
    .we_i   (commit),
    .all_i  (cm_q == CM_ALL),
    .waddr_i(waddr),
    .wdata_i(wdata),
    .wmask_i(wmask),
    .raddr_i(raddr),
    .rdata_o(rword)
  );

  ser_eeprom_timer #(.CYCLES(WR_CYCLES)) u_timer (
    .clk_i, .rst_ni,
    .start_i(commit),
    .busy_o (busy)
  );

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      st_q     <= ST_IDLE;
      cm_q     <= CM_NONE;
      op_q     <= '0;
      adr_q    <= '0;
      dat_q    <= '0;
      sh_q     <= '0;
      cnt_q    <= '0;
      unlk_q   <= 1'b0;
      stat_q   <= 1'b0;
      ones_q   <= 1'b0;
      rd_bit_q <= 1'b0;
    end else begin
      if (!sel_s) begin
        st_q  <= ST_IDLE;
        cm_q  <= CM_NONE;
        cnt_q <= '0;
      end else if (sclk_rise) begin
        unique case (st_q)
          ST_IDLE: begin
            if (sdi_s) begin
              if (stat_q) stat_q <= 1'b0;    // releasing bit, not a start
              else if (!busy) begin
                st_q  <= ST_OPC;
                cnt_q <= '0;
                adr_q <= '0;
              end
            end
          end
          ST_OPC: begin
            op_q <= {op_q[0], sdi_s};
            if (cnt_q == CNT_W'(1)) begin
              st_q  <= ST_ADR;
              cnt_q <= '0;
            end else cnt_q <= cnt_q + CNT_W'(1);
          end
          ST_ADR: begin
            adr_q <= adr_full;
            if (cnt_q != adr_last) cnt_q <= cnt_q + CNT_W'(1);
            else begin
              cnt_q <= '0;
              unique case (op_q)
                OP_RD: begin
                  st_q     <= ST_RD;
                  sh_q     <= rd_val;
                  rd_bit_q <= 1'b0;
                end
                OP_WR: begin
                  st_q   <= ST_DAT;
                  ones_q <= 1'b0;
                end
                OP_ER: begin
                  st_q   <= ST_WAIT;
                  ones_q <= 1'b1;
                  cm_q   <= unlk_q ? CM_WORD : CM_NONE;
                end
                default: begin
                  unique case (ext_sel)
                    EX_UNLOCK: begin
                      unlk_q <= 1'b1;
                      st_q   <= ST_WAIT;
                    end
                    EX_LOCK: begin
                      unlk_q <= 1'b0;
                      st_q   <= ST_WAIT;
                    end
                    EX_FILL_ONES: begin
                      ones_q <= 1'b1;
                      cm_q   <= unlk_q ? CM_ALL : CM_NONE;
                      st_q   <= ST_WAIT;
                    end
                    default: begin
                      ones_q <= 1'b0;
                      st_q   <= ST_DAT;
                    end
                  endcase
                end
              endcase
            end
          end
          ST_DAT: begin
            dat_q <= {dat_q[WORD_W-2:0], sdi_s};
            if (cnt_q != dat_last) cnt_q <= cnt_q + CNT_W'(1);
            else begin
              st_q <= ST_WAIT;
              if (!unlk_q)             cm_q <= CM_NONE;
              else if (op_q == OP_WR)  cm_q <= CM_WORD;
              else                     cm_q <= CM_ALL;
            end
          end
          ST_RD: begin
            rd_bit_q <= wide16_i ? sh_q[WORD_W-1] : sh_q[BYTE_W-1];
            if (cnt_q != dat_last) begin
              cnt_q <= cnt_q + CNT_W'(1);
              sh_q  <= sh_q << 1;
            end else begin
              cnt_q <= '0;
              adr_q <= adr_inc;
              sh_q  <= rd_val;
            end
          end
          default: ;
        endcase
      end
      if (commit) stat_q <= 1'b1;
    end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      sdo_q <= 1'b0;
      oe_q  <= 1'b0;
    end else begin
      oe_q  <= sel_s && (st_q == ST_RD || (st_q == ST_IDLE && stat_q));
      sdo_q <= (st_q == ST_RD) ? rd_bit_q : ~busy;
    end

  assign sdo_o    = sdo_q;
  assign sdo_oe_o = oe_q;
endmodule

// File: rtl/ser_eeprom_chk.sv
module ser_eeprom_chk
  import ser_eeprom_pkg::*;
(
  input logic clk_i,
  input logic rst_ni,
  input logic sel_s,
  input logic sel_fall,
  input logic sclk_rise,
  input logic busy,
  input logic unlk_q,
  input st_e  st_q,
  input cm_e  cm_q,
  input logic sdo_o,
  input logic sdo_oe_o
);
  a_r6_hiz_when_deselected: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sel_s |=> !sdo_oe_o);

  a_r7_busy_drives_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && $past(busy) && sdo_oe_o) |-> !sdo_o);

  a_r8_no_start_while_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && sclk_rise) |=> (st_q == ST_IDLE));

  a_r9_cycle_needs_unlock: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy) |-> $past(unlk_q));

  a_r10_release_aborts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sel_fall |=> (st_q == ST_IDLE && cm_q == CM_NONE));
endmodule

bind ser_eeprom ser_eeprom_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .sel_s    (sel_s),
  .sel_fall (sel_fall),
  .sclk_rise(sclk_rise),
  .busy     (busy),
  .unlk_q   (unlk_q),
  .st_q     (st_q),
  .cm_q     (cm_q),
  .sdo_o    (sdo_o),
  .sdo_oe_o (sdo_oe_o)
);

// File: tb/ser_eeprom_test.sv
module ser_eeprom_test;
  localparam int WR = 600;
  localparam int H  = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic wide16 = 1'b1, sel = 1'b0, sclk = 1'b0, sdi = 1'b0;
  logic sdo, sdo_oe;

  ser_eeprom #(.WR_CYCLES(WR)) uut (
    .clk_i(clk), .rst_ni(rst_n), .wide16_i(wide16),
    .sel_i(sel), .sclk_i(sclk), .sdi_i(sdi),
    .sdo_o(sdo), .sdo_oe_o(sdo_oe)
  );

  always #5 clk = ~clk;

  int n_chk = 0, n_err = 0;
  bit done = 0;
  logic [15:0] model [128];
  bit unlocked = 0;

  typedef struct { logic [15:0] v; string tag; } item_t;
  item_t       exp_q[$];
  logic [15:0] got_q[$];

  task automatic chk(input string tag, input string what, input logic [15:0] act, input logic [15:0] expv);
    n_chk++;
    if (act !== expv) begin
      n_err++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, expv);
    end
  endtask

  function automatic logic [15:0] exp_val(input int a);
    if (wide16) return model[a & 127];
    return (a & 1) ? {8'h00, model[(a & 255) >> 1][15:8]} : {8'h00, model[(a & 255) >> 1][7:0]};
  endfunction

  function automatic void mdl_write(input int a, input logic [15:0] d);
    if (!unlocked) return;
    if (wide16) model[a & 127] = d;
    else if (a & 1) model[(a & 255) >> 1][15:8] = d[7:0];
    else model[(a & 255) >> 1][7:0] = d[7:0];
  endfunction

  task automatic sk_bit(input logic d, output logic o, output logic oe);
    sdi = d;
    repeat (H) @(negedge clk);
    o = sdo; oe = sdo_oe;
    sclk = 1'b1;
    repeat (H) @(negedge clk);
    sclk = 1'b0;
  endtask

  task automatic sel_on();
    sel = 1'b1;
    repeat (H) @(negedge clk);
  endtask

  task automatic sel_off();
    sel = 1'b0; sdi = 1'b0;
    repeat (2*H) @(negedge clk);
  endtask

  task automatic send(input logic [15:0] v, input int n);
    logic o, oe;
    for (int i = n-1; i >= 0; i--) sk_bit(v[i], o, oe);
  endtask

  task automatic hdr(input logic [1:0] op, input logic [7:0] a);
    send(16'h1, 1);
    send({14'h0, op}, 2);
    send({8'h0, a}, wide16 ? 7 : 8);
  endtask

  function automatic logic [7:0] ext_adr(input logic [1:0] code);
    return wide16 ? {1'b0, code, 5'b0} : {code, 6'b0};
  endfunction

  task automatic status_cycle(input bit expect_cycle, input string tag);
    logic o, oe;
    sel_on();
    repeat (6) @(negedge clk);
    if (expect_cycle) begin
      chk("R7", {tag, " busy oe"}, sdo_oe, 1);
      chk("R7", {tag, " busy level"}, sdo, 0);
      repeat (WR) @(negedge clk);
      chk("R7", {tag, " ready level"}, sdo, 1);
      sk_bit(1'b1, o, oe);
      chk("R11", {tag, " released"}, sdo_oe, 0);
    end else begin
      chk(tag, "no cycle started", sdo_oe, 0);
    end
    sel_off();
  endtask

  task automatic set_lock(input bit unlock);
    sel_on(); hdr(2'b00, ext_adr(unlock ? 2'b11 : 2'b00)); sel_off();
    unlocked = unlock;
  endtask

  task automatic write_word(input int a, input logic [15:0] d, input string tag);
    bit en = unlocked;
    sel_on(); hdr(2'b01, 8'(a)); send(d, wide16 ? 16 : 8); sel_off();
    mdl_write(a, d);
    status_cycle(en, tag);
  endtask

  task automatic erase_word(input int a);
    bit en = unlocked;
    sel_on(); hdr(2'b11, 8'(a)); sel_off();
    mdl_write(a, 16'hFFFF);
    status_cycle(en, "R5 erase");
  endtask

  task automatic fill(input bit ones, input logic [15:0] d);
    bit en = unlocked;
    sel_on();
    if (ones) hdr(2'b00, ext_adr(2'b10));
    else begin
      hdr(2'b00, ext_adr(2'b01));
      send(d, wide16 ? 16 : 8);
    end
    sel_off();
    if (en) for (int i = 0; i < 128; i++)
      model[i] = ones ? 16'hFFFF : (wide16 ? d : {d[7:0], d[7:0]});
    status_cycle(en, "R5 fill");
  endtask

  task automatic read_core(input int a, input int n, input string tag);
    logic o, oe;
    logic [15:0] v;
    int ww = wide16 ? 16 : 8;
    hdr(2'b10, 8'(a));
    sk_bit(1'b0, o, oe);
    chk("R3", {tag, " dummy oe"}, oe, 1);
    chk("R3", {tag, " dummy bit"}, o, 0);
    for (int k = 0; k < n; k++) begin
      exp_q.push_back('{exp_val(a + k), tag});
      v = '0;
      for (int b = 0; b < ww; b++) begin
        sk_bit(1'b0, o, oe);
        v = {v[14:0], o};
      end
      got_q.push_back(v);
    end
  endtask

  task automatic read_seq(input int a, input int n, input string tag);
    sel_on(); read_core(a, n, tag); sel_off();
  endtask

  // monitor: compares read words as they come out
  initial begin
    item_t e;
    logic [15:0] g;
    forever begin
      wait (got_q.size() != 0);
      g = got_q.pop_front();
      if (exp_q.size() == 0) chk("scoreboard", "unexpected word", g, 16'hxxxx);
      else begin
        e = exp_q.pop_front();
        chk(e.tag, "read word", g, e.v);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    logic o, oe;
    for (int i = 0; i < 128; i++) model[i] = 16'hFFFF;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R6", "reset oe", sdo_oe, 0);

    read_seq(0, 1, "R1 reset content");
    write_word(3, 16'h1111, "R9 locked write");
    read_seq(3, 1, "R9 locked write kept");

    set_lock(1);
    write_word(5, 16'hA5C3, "R4");
    read_seq(5, 1, "R4 R2 read back");
    write_word(127, 16'h0F0F, "R4");
    write_word(0, 16'h5AA5, "R4");
    read_seq(127, 2, "R3 wrap");
    erase_word(5);
    read_seq(5, 1, "R5 erase");

    // R10: partial write aborted by release
    sel_on(); hdr(2'b01, 8'd9); send(16'h00FF, 8); sel_off();
    status_cycle(0, "R10 abort");
    read_seq(9, 1, "R10 abort kept");

    // R8/R10/R11: release during busy, instruction refused, cycle survives
    sel_on(); hdr(2'b01, 8'd20); send(16'h1357, 16); sel_off();
    mdl_write(20, 16'h1357);
    sel_on();
    repeat (6) @(negedge clk);
    chk("R7", "busy level", sdo, 0);
    sk_bit(1'b1, o, oe);
    chk("R11", "released while busy", sdo_oe, 0);
    hdr(2'b10, 8'd20);
    for (int i = 0; i < 3; i++) begin
      sk_bit(1'b0, o, oe);
      chk("R8", "no read while busy", oe, 0);
    end
    sel_off();
    repeat (WR) @(negedge clk);
    read_seq(20, 1, "R10 cycle kept");

    // R11: releasing 1 directly followed by a read in one selection
    sel_on(); hdr(2'b01, 8'd30); send(16'h2468, 16); sel_off();
    mdl_write(30, 16'h2468);
    sel_on();
    repeat (WR + 6) @(negedge clk);
    chk("R7", "ready before read", sdo, 1);
    sk_bit(1'b1, o, oe);
    read_core(30, 1, "R11 read after release");
    sel_off();

    set_lock(0);
    write_word(5, 16'h0000, "R9 relocked write");
    read_seq(5, 1, "R9 relocked kept");
    set_lock(1);
    fill(1, 16'h0);
    read_seq(64, 1, "R5 fill ones");
    fill(0, 16'h1234);
    read_seq(0, 2, "R5 fill data");

    wide16 = 1'b0;
    repeat (4) @(negedge clk);
    read_seq(11, 1, "R1 byte high");
    read_seq(10, 1, "R1 byte low");
    write_word(21, 16'h009C, "R1 byte write");
    erase_word(4);
    read_seq(4, 2, "R1 byte erase");
    wide16 = 1'b1;
    repeat (4) @(negedge clk);
    read_seq(10, 1, "R1 word view");
    read_seq(2, 1, "R1 word view erase");

    wait (exp_q.size() == 0);
    repeat (10) @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule